// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit holds the event bookkeeping of a register-mapped I2C master controller. The transfer engine reports events as single-cycle pulses on a 16-bit event vector. Each pulse on a defined position sets a sticky status bit. A 5-bit enable register selects which of the low status bits may raise the single interrupt line. Two DMA request lines, one for receive and one for transmit, follow the receive-ready and transmit-ready status bits whenever DMA is enabled for that direction.

Software reaches the unit over a simple register port. The port carries a 6-bit byte offset, 16-bit write data and a combinational read-data return. The port has these offsets:

- 0x00: revision
- 0x02: interrupt enable
- 0x04: status
- 0x06: interrupt vector
- 0x08: DMA configuration

Reading the vector register returns the 1-based position of the lowest pending enabled status bit. That same read acknowledges the bit. Software can therefore service interrupts in a fixed priority order, lowest bit first, with one read each.

Top module: `i2cst_top`

## Requirements
- R1: A synchronous active-high reset clears status, interrupt enable and DMA configuration to zero. While reset is held and after it, irq_o, rx_dma_req_o and tx_dma_req_o are low, and reads of these three registers return 0.
- R2: A pulse on evt_i sets the matching sticky status bit from the next cycle, for bits 1 (no-acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 9 (addressed), 10 (transmit underflow), 11 (receive overrun) and 15 (single byte). Pulses on bits 0, 5–8 and 12–14 are ignored.
- R3: A read at offset 0x04 returns the stored status ORed with bus_busy_i in bit 12.
- R4: A write at offset 0x02 keeps only wdata[4:0]. A read at that offset returns the kept value zero-extended. irq_o is high exactly when (status AND enable) is nonzero.
- R5: A read at offset 0x06 returns the 1-based index of the least significant set bit of (status AND enable), or 0 when none is set. When the result is nonzero, that status bit is cleared at the end of the read cycle.
- R6: When an event pulse and a vector-read clear hit the same status bit in one cycle, the bit stays set.
- R7: A write at offset 0x08 stores wdata AND 0x8080. Bit 15 is the receive DMA enable and bit 7 is the transmit DMA enable. A read at that offset returns the stored value.
- R8: A DMA configuration write with wdata[15] set clears enable bit 3. A DMA configuration write with wdata[7] set clears enable bit 4.
- R9: rx_dma_req_o equals DMA bit 15 AND status bit 3. tx_dma_req_o equals DMA bit 7 AND status bit 4.
- R10: Writes at offsets 0x04 and 0x06 leave all state unchanged. For each such write, bad_access_o is high for exactly the one cycle that follows the write.
- R11: A read at offset 0x00 returns 0x0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects at the cycle's end) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the strobe cycle |
| bad_access_o | output | 1 | Pulse after a write to a read-only register |
| bus_busy_i | input | 1 | Live bus-busy flag from the transfer engine |
| evt_i | input | 16 | Event pulses, one per status position |
| irq_o | output | 1 | Interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. Status, enable and DMA updates, and therefore irq_o and both DMA requests, become visible one clock edge after the event or access that caused them. bad_access_o is due exactly one cycle after the offending write. The bench applies each stimulus at a falling edge. It samples read data a quarter period later, before the rising edge, and samples irq_o, the DMA requests and bad_access_o a quarter period after that rising edge.

// File: rtl/i2cst_pkg.sv
`timescale 1ns/1ps
package i2cst_pkg;

    localparam int DATA_W = 16;
    localparam int IE_W   = 5;
    localparam int VEC_W  = $clog2(DATA_W + 1);

    // status bit positions
    localparam int POS_NACK = 1;
    localparam int POS_ARDY = 2;
    localparam int POS_RRDY = 3;
    localparam int POS_XRDY = 4;
    localparam int POS_AAS  = 9;
    localparam int POS_XUDF = 10;
    localparam int POS_ROVR = 11;
    localparam int POS_BUSY = 12;
    localparam int POS_SBD  = 15;

    localparam logic [DATA_W-1:0] STICKY_MASK =
        DATA_W'((1 << POS_NACK) | (1 << POS_ARDY) | (1 << POS_RRDY) |
                (1 << POS_XRDY) | (1 << POS_AAS)  | (1 << POS_XUDF) |
                (1 << POS_ROVR) | (1 << POS_SBD));

    // DMA lanes: 0 = receive, 1 = transmit
    localparam int NUM_LANES = 2;
    localparam int DMA_EN_POS [NUM_LANES] = '{15, 7};
    localparam int READY_POS  [NUM_LANES] = '{POS_RRDY, POS_XRDY};
    localparam logic [DATA_W-1:0] DMA_KEEP = 16'h8080;

    typedef enum logic [5:0] {
        OFF_REV    = 6'h00,
        OFF_ENABLE = 6'h02,
        OFF_STATUS = 6'h04,
        OFF_VECTOR = 6'h06,
        OFF_DMACFG = 6'h08
    } reg_off_e;

    typedef struct packed {
        logic rev;
        logic enable;
        logic status;
        logic vector;
        logic dmacfg;
    } reg_hit_t;

    // 1-based index of lowest set bit, 0 when none
    function automatic logic [VEC_W-1:0] lowest_pos(input logic [DATA_W-1:0] v);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (v[i]) r = VEC_W'(i + 1);
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pos_to_mask(input logic [VEC_W-1:0] p);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (p == VEC_W'(i + 1)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/i2cst_status.sv
`timescale 1ns/1ps
module i2cst_status
    import i2cst_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   evt_i,
    input  logic [IE_W-1:0]     en_i,
    input  logic                vec_rd_i,
    output logic [DATA_W-1:0]   stat_o,
    output logic [VEC_W-1:0]    vec_o
);

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] set_m;
    logic [DATA_W-1:0] clr_m;

    assign pending = stat_q & {{(DATA_W-IE_W){1'b0}}, en_i};
    assign vec_o   = lowest_pos(pending);
    assign set_m   = evt_i & STICKY_MASK;
    assign clr_m   = (vec_rd_i && vec_o != '0) ? pos_to_mask(vec_o) : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_m) | set_m;
    end

    assign stat_o = stat_q;

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
        ((evt_i & STICKY_MASK) != '0) |=>
        ((stat_q & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK))); // R6
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (evt_i == '0 && !vec_rd_i) |=> $stable(stat_q)); // R2
    AST_VEC_ACKS_ONE: assert property (@(posedge clk) disable iff (rst)
        (vec_rd_i && evt_i == '0 && (stat_q & {{(DATA_W-IE_W){1'b0}}, en_i}) != '0) |=>
        ($countones(stat_q) == $countones($past(stat_q)) - 1)); // R5

endmodule

// File: rtl/i2cst_cfg.sv
`timescale 1ns/1ps
module i2cst_cfg
    import i2cst_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ie_we_i,
    input  logic                dma_we_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [IE_W-1:0]     ie_o,
    output logic [DATA_W-1:0]   dma_o
);

    logic [IE_W-1:0]   ie_q, ie_n;
    logic [DATA_W-1:0] dma_q, dma_n;

    always_comb begin
        ie_n  = ie_q;
        dma_n = dma_q;
        if (ie_we_i) begin
            ie_n = wdata_i[IE_W-1:0];
        end else if (dma_we_i) begin
            dma_n = wdata_i & DMA_KEEP;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (wdata_i[DMA_EN_POS[l]]) ie_n[READY_POS[l]] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= '0;
            dma_q <= '0;
        end else begin
            ie_q  <= ie_n;
            dma_q <= dma_n;
        end
    end

    assign ie_o  = ie_q;
    assign dma_o = dma_q;

    AST_IE_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        ie_we_i |=> (ie_q == $past(wdata_i[IE_W-1:0]))); // R4
    AST_RXDMA_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
        (dma_we_i && !ie_we_i && wdata_i[DMA_EN_POS[0]]) |=> !ie_q[POS_RRDY]); // R8
    AST_TXDMA_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
        (dma_we_i && !ie_we_i && wdata_i[DMA_EN_POS[1]]) |=> !ie_q[POS_XRDY]); // R8

endmodule

// File: rtl/i2cst_top.sv
`timescale 1ns/1ps
module i2cst_top
    import i2cst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [DATA_W-1:0] REV_VALUE = 16'h0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              bad_access_o,
    input  logic              bus_busy_i,
    input  logic [15:0]       evt_i,
    output logic              irq_o,
    output logic              rx_dma_req_o,
    output logic              tx_dma_req_o
);

    reg_hit_t          hit;
    logic [DATA_W-1:0] stat_w;
    logic [VEC_W-1:0]  vec_w;
    logic [IE_W-1:0]   ie_w;
    logic [DATA_W-1:0] dma_w;
    logic [NUM_LANES-1:0] dma_req;
    logic              bad_q;

    always_comb begin
        hit.rev    = (reg_addr_i == ADDR_W'(OFF_REV));
        hit.enable = (reg_addr_i == ADDR_W'(OFF_ENABLE));
        hit.status = (reg_addr_i == ADDR_W'(OFF_STATUS));
        hit.vector = (reg_addr_i == ADDR_W'(OFF_VECTOR));
        hit.dmacfg = (reg_addr_i == ADDR_W'(OFF_DMACFG));
    end

    i2cst_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_i),
        .en_i     (ie_w),
        .vec_rd_i (reg_rd_i && hit.vector),
        .stat_o   (stat_w),
        .vec_o    (vec_w)
    );

    i2cst_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ie_we_i  (reg_wr_i && hit.enable),
        .dma_we_i (reg_wr_i && hit.dmacfg),
        .wdata_i  (reg_wdata_i),
        .ie_o     (ie_w),
        .dma_o    (dma_w)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (1'b1)
            hit.rev:    reg_rdata_o = REV_VALUE;
            hit.enable: reg_rdata_o = {{(DATA_W-IE_W){1'b0}}, ie_w};
            hit.status: reg_rdata_o = stat_w | (DATA_W'(bus_busy_i) << POS_BUSY);
            hit.vector: reg_rdata_o = {{(DATA_W-VEC_W){1'b0}}, vec_w};
            hit.dmacfg: reg_rdata_o = dma_w;
            default:    reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bad_q <= 1'b0;
        else     bad_q <= reg_wr_i && (hit.status || hit.vector);
    end
    assign bad_access_o = bad_q;

    assign irq_o = |(stat_w & {{(DATA_W-IE_W){1'b0}}, ie_w});

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign dma_req[g] = dma_w[DMA_EN_POS[g]] & stat_w[READY_POS[g]];
    end
    assign rx_dma_req_o = dma_req[0];
    assign tx_dma_req_o = dma_req[1];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (stat_w == '0 && ie_w == '0 && dma_w == '0)); // R1
    AST_RO_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && (hit.status || hit.vector)) |=> bad_access_o); // R10
    AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && !reg_rd_i && (hit.status || hit.vector) && evt_i == '0) |=>
        ($stable(stat_w) && $stable(ie_w) && $stable(dma_w))); // R10
    AST_RXREQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !dma_w[DMA_EN_POS[0]] |-> !rx_dma_req_o); // R9
    AST_TXREQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !dma_w[DMA_EN_POS[1]] |-> !tx_dma_req_o); // R9

endmodule

// File: tb/i2cst_tb_top.sv
`timescale 1ns/1ps
module i2cst_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;
    localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [15:0] wd;
        logic [15:0] evt;
        logic        busy;
        logic [15:0] exp_rd;
        logic        exp_irq;
        logic        exp_rx;
        logic        exp_tx;
        logic        exp_bad;
        logic [3:0]  req;
    } row_t;

    localparam int N_ROWS = 25;
    localparam row_t TBL [N_ROWS] = '{
        '{OP_RD,   6'h00, 16'h0000, 16'h0000, 1'b0, 16'h0011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b1, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{OP_IDLE, 6'h00, 16'h0000, 16'h0008, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b0, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{OP_WR,   6'h02, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{OP_RD,   6'h02, 16'h0000, 16'h0000, 1'b0, 16'h001F, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{OP_IDLE, 6'h00, 16'h0000, 16'h71E1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b0, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{OP_IDLE, 6'h00, 16'h0000, 16'h8E16, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b1, 16'h9E1E, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{OP_RD,   6'h06, 16'h0000, 16'h0000, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{OP_RD,   6'h06, 16'h0000, 16'h0000, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{OP_WR,   6'h08, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8
        '{OP_RD,   6'h08, 16'h0000, 16'h0000, 1'b0, 16'h8080, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},  // R7
        '{OP_RD,   6'h02, 16'h0000, 16'h0000, 1'b0, 16'h0007, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8
        '{OP_RD,   6'h06, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b0, 16'h8E18, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        '{OP_WR,   6'h08, 16'h0080, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
        '{OP_WR,   6'h02, 16'h0008, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
        '{OP_RD,   6'h06, 16'h0000, 16'h0008, 1'b0, 16'h0004, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b0, 16'h8E18, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{OP_RD,   6'h06, 16'h0000, 16'h0000, 1'b0, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        '{OP_WR,   6'h04, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}, // R10
        '{OP_WR,   6'h06, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}, // R10
        '{OP_RD,   6'h04, 16'h0000, 16'h0000, 1'b0, 16'h8E10, 1'b0, 1'b0, 1'b1, 1'b0, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bad_access;
    logic        bus_busy = 1'b0;
    logic [15:0] evt = '0;
    logic        irq, rx_req, tx_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cst_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_wr_i     (reg_wr),
        .reg_rd_i     (reg_rd),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .bad_access_o (bad_access),
        .bus_busy_i   (bus_busy),
        .evt_i        (evt),
        .irq_o        (irq),
        .rx_dma_req_o (rx_req),
        .tx_dma_req_o (tx_req)
    );

    task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; evt = '0; bus_busy = 1'b0;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic run_row(input row_t r);
        reg_wr = (r.op == OP_WR); reg_rd = (r.op == OP_RD);
        reg_addr = r.addr; reg_wdata = r.wd; evt = r.evt; bus_busy = r.busy;
        #(Q);
        if (r.op == OP_RD) check(int'(r.req), "read data", reg_rdata, r.exp_rd);
        @(posedge clk); #(Q);
        check(int'(r.req), "irq_o", 16'(irq), 16'(r.exp_irq));
        check(int'(r.req), "rx_dma_req_o", 16'(rx_req), 16'(r.exp_rx));
        check(int'(r.req), "tx_dma_req_o", 16'(tx_req), 16'(r.exp_tx));
        check(int'(r.req), "bad_access_o", 16'(bad_access), 16'(r.exp_bad));
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_reg(input int req, input string what, input logic [5:0] a, input logic [15:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        #(Q);
        check(req, what, reg_rdata, exp);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values during reset
        read_reg(1, "status in reset", 6'h04, 16'h0000);
        read_reg(1, "enable in reset", 6'h02, 16'h0000);
        read_reg(1, "dma cfg in reset", 6'h08, 16'h0000);
        check(1, "irq_o in reset", 16'(irq), 16'h0000);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < N_ROWS; i++) run_row(TBL[i]);

        // R1: reset in mid-run wipes the programmed state
        rst = 1'b1;
        @(posedge clk); #(Q);
        check(1, "tx_dma_req_o after reset", 16'(tx_req), 16'h0000);
        check(1, "irq_o after reset", 16'(irq), 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        read_reg(1, "status after reset", 6'h04, 16'h0000);
        read_reg(1, "enable after reset", 6'h02, 16'h0000);
        read_reg(1, "dma cfg after reset", 6'h08, 16'h0000);

        // R5: vector with only a high, non-enabled bit pending returns 0
        evt = 16'h8000;
        @(negedge clk);
        idle_inputs();
        read_reg(5, "vector with no enabled bit", 6'h06, 16'h0000);
        read_reg(5, "status kept after zero vector", 6'h04, 16'h8000);

        // R10: bad_access_o lasts exactly one cycle
        reg_wr = 1'b1; reg_addr = 6'h04; reg_wdata = 16'hFFFF;
        @(posedge clk); #(Q);
        check(10, "bad pulse", 16'(bad_access), 16'h0001);
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #(Q);
        check(10, "bad pulse ends", 16'(bad_access), 16'h0000);
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule